// File: doc/BRIEF.md
# Multi-Channel Slow-Control Dispatcher

The dispatcher sends short command messages to twelve front-end channels and gathers their short replies. Each channel owns a 128-byte transmit store made of eight 16-byte command slots. The host fills these stores ahead of time. It then starts a round of messages with one write of a 32-bit control word. That word carries a 2-bit length code for each channel and one 3-bit slot index that every channel shares. Each channel with a nonzero code streams that many bytes out of the chosen slot. The bytes leave on the channel's own valid/ready byte output. All twelve channels run at the same time and do not depend on one another.

Each channel's output follows a simple back-pressure rule. The channel raises `tx_valid` while bytes remain in its message. It holds `tx_data` steady until the downstream side answers with `tx_ready`. A byte counts as sent on every cycle in which valid and ready are both high. Reply bytes come in on a per-channel valid/ready byte input. `rx_ready` is always high, so a reply byte is taken on every cycle its valid is high. The first four reply bytes since the last control write are kept in order. Any later reply bytes are dropped. A status word flags each channel that holds reply data.

The host watches progress by reading the control word back. A channel's code falls to zero once its final byte has been accepted downstream. The round is over when every code field reads zero. Writing the control word in the middle of a message restarts that channel from byte 0 with the new code. If a control write and a reply byte arrive in the same cycle, the control write wins and the reply byte is dropped.

Top module: `sc_dispatch`

## Requirements
- R1: The length codes decode as follows: 2'b00 sends 0 bytes, 2'b01 sends 2 bytes, 2'b10 sends 3 bytes and 2'b11 sends 10 bytes.
- R2: A control write places channel c's code (c = 0..11) in `ctl_wdata[2c+1:2c]` and the slot index in `ctl_wdata[31:29]`. On the cycle after the write, `ctl_rdata` returns these same fields, with bits 28:24 reading zero.
- R3: Byte k of channel c's message equals the byte that was written with `txb_chan`=c and `txb_addr`=slot*16+k.
- R4: While `tx_valid[c]` is high and `tx_ready[c]` is low, the byte is held and `tx_valid[c]` stays high. The message advances by exactly one byte on each cycle in which both are high.
- R5: A channel's code returns to 2'b00 in the cycle after its last byte is accepted. `tx_valid` never rises without a control write. `ctl_rdata[23:0]` reads zero once all messages are done.
- R6: All channels transmit in parallel. Back-pressure on one channel does not affect any other channel.
- R7: Reply bytes for channel c are stored in arrival order at `rxb_addr` 0, 1, 2 and 3 of `rxb_chan`=c. Any reply byte after the fourth is discarded.
- R8: `rxstat[c]` becomes 1 after channel c receives a reply byte and stays 1 until the next control write. `rxstat[31:12]` reads zero.
- R9: A control write clears `rxstat` to zero and sends the next reply byte of each channel back to `rxb_addr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: length codes and slot index |
| ctl_rdata | output | 32 | Pending codes in bits 23:0, slot index in bits 31:29 |
| rxstat | output | 32 | Bit c set when channel c holds reply data |
| txb_we | input | 1 | Transmit store write enable |
| txb_chan | input | 4 | Transmit store channel select |
| txb_addr | input | 7 | Byte address within the channel's transmit store |
| txb_wdata | input | 8 | Transmit store write byte |
| rxb_chan | input | 4 | Reply store channel select |
| rxb_addr | input | 2 | Reply byte position |
| rxb_rdata | output | 8 | Reply byte read data (combinational) |
| tx_valid | output | 12 | Per-channel output byte valid |
| tx_data | output | 96 | Per-channel output byte, channel c in bits 8c+7:8c |
| tx_ready | input | 12 | Per-channel downstream ready |
| rx_valid | input | 12 | Per-channel reply byte valid |
| rx_data | input | 96 | Per-channel reply byte, channel c in bits 8c+7:8c |
| rx_ready | output | 12 | Per-channel reply ready, always high |

## Verification
A wrong position counter or length decode shows up within the same message. Either the byte count seen at `tx_data` does not match the code, or a byte comes from the wrong slot address. The affected code field in `ctl_rdata` then clears too early or too late, one cycle after the accepted byte where the error lies. A wrong receive pointer shows at `rxb_rdata` as soon as the reply bytes are read back. A status flag that fails to clear is visible in `rxstat` on the cycle right after the control write.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Number of bytes sent for a 2-bit length code
  function automatic logic [3:0] code_len(input logic [1:0] code);
    case (code)
      2'b01:   code_len = 4'd2;
      2'b10:   code_len = 4'd3;
      2'b11:   code_len = 4'd10;
      default: code_len = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/sc_txbuf.sv
module sc_txbuf #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_lane.sv
module sc_lane #(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 16,
  parameter int RX_BYTES   = 4,
  localparam int SW  = $clog2(SLOTS),
  localparam int BW  = $clog2(SLOT_BYTES),
  localparam int AW  = SW + BW,
  localparam int RIW = $clog2(RX_BYTES),
  localparam int RCW = $clog2(RX_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    buf_we,
  input  logic [AW-1:0]           buf_addr,
  input  logic [7:0]              buf_wdata,
  input  logic                    start,
  input  logic [1:0]              start_code,
  input  logic [SW-1:0]           slot,
  output logic [1:0]              code_o,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  input  logic                    tx_ready,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic [RX_BYTES*8-1:0]   rx_bytes,
  output logic                    rx_flag
);
  logic [1:0]    code_q;
  logic [BW-1:0] pos_q;
  logic [3:0]    len;
  logic          last;
  logic [RCW-1:0] rx_cnt;
  logic [RX_BYTES-1:0][7:0] rx_mem;

  sc_txbuf #(.DEPTH(SLOTS * SLOT_BYTES)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr ({slot, pos_q}),
    .rdata (tx_data)
  );

  assign len      = sc_pkg::code_len(code_q);
  assign last     = ({{(8-BW){1'b0}}, pos_q} == 8'(len - 4'd1));
  assign tx_valid = (code_q != 2'b00);
  assign code_o   = code_q;
  assign rx_bytes = rx_mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= 2'b00;
      pos_q  <= '0;
    end else if (start) begin
      code_q <= start_code;
      pos_q  <= '0;
    end else if (tx_valid && tx_ready) begin
      if (last) begin
        code_q <= 2'b00;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt  <= '0;
      rx_flag <= 1'b0;
      rx_mem  <= '0;
    end else if (start) begin
      rx_cnt  <= '0;
      rx_flag <= 1'b0;
    end else if (rx_valid) begin
      rx_flag <= 1'b1;
      if (rx_cnt < RCW'(RX_BYTES)) begin
        rx_mem[rx_cnt[RIW-1:0]] <= rx_data;
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_dispatch.sv
module sc_dispatch #(
  parameter int NCH        = 12,
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 16,
  parameter int RX_BYTES   = 4,
  localparam int CHW = $clog2(NCH),
  localparam int SW  = $clog2(SLOTS),
  localparam int AW  = SW + $clog2(SLOT_BYTES),
  localparam int RIW = $clog2(RX_BYTES),
  localparam int IDX_LSB = 32 - SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  output logic [31:0]       rxstat,
  input  logic              txb_we,
  input  logic [CHW-1:0]    txb_chan,
  input  logic [AW-1:0]     txb_addr,
  input  logic [7:0]        txb_wdata,
  input  logic [CHW-1:0]    rxb_chan,
  input  logic [RIW-1:0]    rxb_addr,
  output logic [7:0]        rxb_rdata,
  output logic [NCH-1:0]    tx_valid,
  output logic [NCH*8-1:0]  tx_data,
  input  logic [NCH-1:0]    tx_ready,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*8-1:0]  rx_data,
  output logic [NCH-1:0]    rx_ready
);
  logic [SW-1:0]                     slot_q;
  logic [2*NCH-1:0]                  codes;
  logic [NCH-1:0]                    flags;
  logic [NCH-1:0][RX_BYTES*8-1:0]    rx_all;

  always_ff @(posedge clk) begin
    if (!rst_n)      slot_q <= '0;
    else if (ctl_wr) slot_q <= ctl_wdata[31:IDX_LSB];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    sc_lane #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .RX_BYTES(RX_BYTES)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .buf_we     (txb_we && (txb_chan == CHW'(i))),
      .buf_addr   (txb_addr),
      .buf_wdata  (txb_wdata),
      .start      (ctl_wr),
      .start_code (ctl_wdata[2*i +: 2]),
      .slot       (slot_q),
      .code_o     (codes[2*i +: 2]),
      .tx_valid   (tx_valid[i]),
      .tx_data    (tx_data[8*i +: 8]),
      .tx_ready   (tx_ready[i]),
      .rx_valid   (rx_valid[i]),
      .rx_data    (rx_data[8*i +: 8]),
      .rx_bytes   (rx_all[i]),
      .rx_flag    (flags[i])
    );
  end

  assign rx_ready = '1;

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[2*NCH-1:0]   = codes;
    ctl_rdata[31:IDX_LSB]  = slot_q;
    rxstat = '0;
    rxstat[NCH-1:0] = flags;
    rxb_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rxb_chan == CHW'(c)) rxb_rdata = rx_all[c][8*rxb_addr +: 8];
    end
  end
endmodule

// File: rtl/sc_dispatch_chk.sv
module sc_dispatch_chk #(
  parameter int NCH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [31:0]      ctl_wdata,
  input logic [31:0]      ctl_rdata,
  input logic [31:0]      rxstat,
  input logic [NCH-1:0]   tx_valid,
  input logic [NCH-1:0]   tx_ready,
  input logic [NCH-1:0]   rx_valid
);
  // R2
  codes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata[2*NCH-1:0] == $past(ctl_wdata[2*NCH-1:0]));

  // R2
  slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata[31:24] == {$past(ctl_wdata[31:29]), 5'b0});

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> (($past(tx_valid & ~tx_ready) & ~tx_valid) == '0));

  // R5
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ((tx_valid & ~$past(tx_valid)) == '0));

  // R8
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> (($past(rx_valid) & ~rxstat[NCH-1:0]) == '0));

  // R8
  rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> (($past(rxstat) & ~rxstat) == '0));

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> rxstat == '0);
endmodule

bind sc_dispatch sc_dispatch_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .rxstat    (rxstat),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid)
);

// File: tb/sc_dispatch_bench.sv
module sc_dispatch_bench;
  localparam int NCH = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_wr = 1'b0;
  logic [31:0]       ctl_wdata = '0;
  logic [31:0]       ctl_rdata;
  logic [31:0]       rxstat;
  logic              txb_we = 1'b0;
  logic [3:0]        txb_chan = '0;
  logic [6:0]        txb_addr = '0;
  logic [7:0]        txb_wdata = '0;
  logic [3:0]        rxb_chan = '0;
  logic [1:0]        rxb_addr = '0;
  logic [7:0]        rxb_rdata;
  logic [NCH-1:0]    tx_valid;
  logic [NCH*8-1:0]  tx_data;
  logic [NCH-1:0]    tx_ready = '0;
  logic [NCH-1:0]    rx_valid = '0;
  logic [NCH*8-1:0]  rx_data = '0;
  logic [NCH-1:0]    rx_ready;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit bp = 0;
  int cyc = 0;
  int got [NCH];
  int exp_slot [NCH];

  // {chan[3:0], code[1:0], slot[2:0]}
  localparam logic [8:0] VEC [8] = '{
    {4'd0,  2'b01, 3'd0}, {4'd11, 2'b11, 3'd7}, {4'd5, 2'b10, 3'd3},
    {4'd3,  2'b11, 3'd1}, {4'd7,  2'b01, 3'd6}, {4'd1, 2'b00, 3'd2},
    {4'd9,  2'b10, 3'd5}, {4'd6,  2'b11, 3'd4}
  };

  sc_dispatch u_sc_dispatch (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int ch, int a);
    return 8'(ch * 37 + a * 5 + 3);
  endfunction

  function automatic int lenof(logic [1:0] c);
    return (c == 2'b01) ? 2 : (c == 2'b10) ? 3 : (c == 2'b11) ? 10 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr_ctl(logic [31:0] w);
    @(negedge clk);
    tx_ready = '0;
    ctl_wr = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
    for (int c = 0; c < NCH; c++) got[c] = 0;
    #1;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) tx_ready[c] = bp ? (((cyc + c) % 3) != 0) : 1'b1;
      #1;
      for (int c = 0; c < NCH; c++) begin
        if (tx_valid[c] && tx_ready[c]) begin
          check(tx_data[8*c +: 8] == pat(c, exp_slot[c] * 16 + got[c]), "R3 byte",
                tx_data[8*c +: 8], pat(c, exp_slot[c] * 16 + got[c]));
          got[c]++;
        end
      end
      cyc++;
    end
  endtask

  task automatic send_rx(int ch, logic [7:0] d);
    @(negedge clk);
    rx_valid[ch] = 1'b1;
    rx_data[8*ch +: 8] = d;
    @(negedge clk);
    rx_valid = '0;
  endtask

  task automatic read_rx(int ch, int a, logic [7:0] e, string req);
    rxb_chan = 4'(ch);
    rxb_addr = 2'(a);
    #1;
    check(rxb_rdata == e, req, rxb_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(ctl_rdata == 0, "reset ctl_rdata", ctl_rdata, 0);
    check(rxstat == 0, "reset rxstat", rxstat, 0);
    check(tx_valid == 0, "reset tx_valid", tx_valid, 0);

    // fill all transmit stores
    for (int c = 0; c < NCH; c++) begin
      for (int a = 0; a < 128; a++) begin
        @(negedge clk);
        txb_we = 1'b1; txb_chan = 4'(c); txb_addr = 7'(a); txb_wdata = pat(c, a);
      end
    end
    @(negedge clk);
    txb_we = 1'b0;

    // table walk: single-channel messages (R1, R2, R3, R5)
    for (int v = 0; v < 8; v++) begin
      int ch;
      logic [1:0] code;
      logic [2:0] slot;
      logic [31:0] w;
      ch = int'(VEC[v][8:5]);
      code = VEC[v][4:3];
      slot = VEC[v][2:0];
      w = '0;
      w[2*ch +: 2] = code;
      w[31:29] = slot;
      w[27:24] = 4'hF;
      exp_slot[ch] = int'(slot);
      wr_ctl(w);
      check(ctl_rdata == {slot, 5'b0, w[23:0]}, "R2 readback", ctl_rdata, {slot, 5'b0, w[23:0]});
      bp = 0;
      run(14);
      check(got[ch] == lenof(code), "R1 byte count", got[ch], lenof(code));
      check(ctl_rdata[23:0] == 0, "R5 codes cleared", ctl_rdata[23:0], 0);
      check(tx_valid == 0, "R5 idle", tx_valid, 0);
    end

    // back-pressure hold (R4)
    exp_slot[2] = 1;
    wr_ctl({3'd1, 29'(2'b10 << 4)});
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      check(tx_valid[2] == 1'b1, "R4 valid held", tx_valid[2], 1);
      check(tx_data[23:16] == pat(2, 16), "R4 data held", tx_data[23:16], pat(2, 16));
    end
    bp = 0;
    run(6);
    check(got[2] == 3, "R4 count after stall", got[2], 3);

    // all channels in parallel under mixed back-pressure (R6)
    for (int c = 0; c < NCH; c++) exp_slot[c] = 2;
    wr_ctl({3'd2, 5'd0, 24'hFFFFFF});
    bp = 1;
    run(40);
    for (int c = 0; c < NCH; c++) check(got[c] == 10, "R6 parallel count", got[c], 10);
    check(ctl_rdata[23:0] == 0, "R5 all done", ctl_rdata[23:0], 0);
    bp = 0;

    // reply capture (R7, R8)
    wr_ctl(32'h0);
    for (int k = 0; k < 6; k++) send_rx(4, 8'hA0 + 8'(k));
    #1;
    check(rxstat == 32'h10, "R8 status bit", rxstat, 32'h10);
    for (int k = 0; k < 4; k++) read_rx(4, k, 8'hA0 + 8'(k), "R7 order/discard");
    send_rx(0, 8'h3C);
    #1;
    check(rxstat == 32'h11, "R8 second channel", rxstat, 32'h11);
    read_rx(0, 0, 8'h3C, "R7 channel 0");

    // control write clears and restarts (R9)
    wr_ctl(32'h0);
    check(rxstat == 0, "R9 status cleared", rxstat, 0);
    send_rx(4, 8'h55);
    #1;
    read_rx(4, 0, 8'h55, "R9 restart at 0");
    read_rx(4, 1, 8'hA1, "R9 later bytes untouched");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule